// File: doc/BRIEF.md
# Audio Infoframe Packet Buffer and Scheduler

This block holds one audio infoframe plus the enable and repeat controls for four kinds of data-island packet. A host writes the three header bytes, the five leading payload bytes and two control registers through a simple write port. The checksum is never written by the host: the block derives it from the header and payload so that the packet always sums to zero modulo 256.

On each vertical-blanking strobe the block decides which enabled packets go out in that blanking period and streams them one byte per cycle over a valid/ready interface with a last marker. The audio infoframe goes out in full. The other three packet kinds (general control, video infoframe, generic) have their bodies assembled downstream, so for each of these the block emits a single descriptor byte carrying its type code. A packet either goes out on one frame only and then disarms itself, or goes out on every frame until the host disarms it.

Top module: `audio_ifr_pktbuf`

## Requirements
- R1: After reset the header registers hold type 0x84, version 0x01 and length 0x0A, all payload bytes are 0x00, every enable and repeat bit is clear (a strobe sends nothing), and out_valid is low.
- R2: An audio infoframe is 14 bytes in this order: type, version, length, checksum, host payload bytes 1 to 5 (register addresses 5 to 9), then five 0x00 bytes. out_last is high only on the 14th byte.
- R3: The checksum byte is (0x100 − sum of the three header bytes and all ten payload bytes) mod 256.
- R4: Register address 0 holds audio enable in bit 5, audio repeat in bit 4, video infoframe enable in bit 1 and video repeat in bit 0. Address 1 holds general control enable in bit 3, its repeat in bit 2, generic enable in bit 1 and generic repeat in bit 0. The descriptor bytes are 0x03 for general control, 0x82 for video infoframe and 0x81 for generic, each a one-byte packet with out_last high. A repeat bit with its enable clear sends nothing.
- R5: A packet enabled with its repeat bit clear is sent on the next accepted strobe only; its enable bit clears itself at that strobe.
- R6: A packet with enable and repeat set is sent on every accepted strobe until the host clears its enable.
- R7: Packets due on the same strobe leave in the order general control, video infoframe, audio infoframe, generic, each one finished before the next starts.
- R8: While out_valid is high and out_ready is low, out_valid, out_data and out_last hold their values.
- R9: Host writes to header or payload registers while packets are in flight do not change the packet being sent; they appear from the next accepted strobe.
- R10: A strobe that arrives while any packet of the current frame is still pending is ignored; enables armed meanwhile wait for a later strobe.
- R11: Header bytes written by the host replace the defaults in the stream, and the checksum follows them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | ADDR_W | Host register address (0,1 control; 2..4 header; 5..9 payload) |
| wr_data | input | 8 | Host write data |
| frame_strobe | input | 1 | Vertical-blanking strobe, one cycle |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | 8 | Stream byte |
| out_last | output | 1 | Final byte of the current packet |

## Verification
A wrong pending mask or a missed self-clear shows at the ports on the strobe after the fault: a packet appears that should not, is missing, or comes out of priority order, within the first byte after the strobe. A corrupt snapshot or a bad byte counter shows inside the same audio packet as a wrong checksum byte, a shifted payload or out_last on the wrong beat. Backpressure faults appear as data changing while out_ready is low, within a single cycle of the stall.

// File: rtl/aifb_pkg.sv
package aifb_pkg;
   localparam int DW   = 8;
   localparam int NPKT = 4;

   // index order is also the send priority: lower index leaves first
   typedef enum logic [1:0] {
      PK_GCP = 2'd0,
      PK_VID = 2'd1,
      PK_AUD = 2'd2,
      PK_GEN = 2'd3
   } pkt_e;

   localparam int A_CTLA = 0;
   localparam int A_CTLB = 1;
   localparam int A_TYPE = 2;
   localparam int A_VER  = 3;
   localparam int A_LEN  = 4;
   localparam int A_PAY0 = 5;

   localparam logic [DW-1:0] TOK_GCP = 8'h03;
   localparam logic [DW-1:0] TOK_VID = 8'h82;
   localparam logic [DW-1:0] TOK_GEN = 8'h81;

   localparam logic [DW-1:0] HDR_TYPE_RST = 8'h84;
   localparam logic [DW-1:0] HDR_VER_RST  = 8'h01;
   localparam logic [DW-1:0] HDR_LEN_RST  = 8'h0A;
endpackage

// File: rtl/aifb_regs.sv
module aifb_regs
   import aifb_pkg::*;
#(
   parameter int ADDR_W     = 4,
   parameter int HOST_BYTES = 5
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [ADDR_W-1:0]              wr_addr,
   input  logic [DW-1:0]                  wr_data,
   input  logic                           take,
   output logic [NPKT-1:0]                en_o,
   output logic [NPKT-1:0]                rpt_o,
   output logic [2:0][DW-1:0]             hdr_o,
   output logic [HOST_BYTES-1:0][DW-1:0]  pay_o
);
   logic [NPKT-1:0]               en_q, rpt_q;
   logic [2:0][DW-1:0]            hdr_q;
   logic [HOST_BYTES-1:0][DW-1:0] pay_q;
   logic                          wr_ctla;

   assign wr_ctla = wr_en && (int'(wr_addr) == A_CTLA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         rpt_q <= '0;
         hdr_q <= {HDR_LEN_RST, HDR_VER_RST, HDR_TYPE_RST};
         pay_q <= '0;
      end else begin
         // one-shot packets disarm on the strobe that schedules them
         if (take) begin
            for (int k = 0; k < NPKT; k++)
               if (en_q[k] && !rpt_q[k]) en_q[k] <= 1'b0;
         end
         // a host write in the same cycle overrides the disarm
         if (wr_en) begin
            if (int'(wr_addr) == A_CTLA) begin
               en_q[PK_AUD]  <= wr_data[5];
               rpt_q[PK_AUD] <= wr_data[4];
               en_q[PK_VID]  <= wr_data[1];
               rpt_q[PK_VID] <= wr_data[0];
            end
            if (int'(wr_addr) == A_CTLB) begin
               en_q[PK_GCP]  <= wr_data[3];
               rpt_q[PK_GCP] <= wr_data[2];
               en_q[PK_GEN]  <= wr_data[1];
               rpt_q[PK_GEN] <= wr_data[0];
            end
            if (int'(wr_addr) == A_TYPE) hdr_q[0] <= wr_data;
            if (int'(wr_addr) == A_VER)  hdr_q[1] <= wr_data;
            if (int'(wr_addr) == A_LEN)  hdr_q[2] <= wr_data;
            for (int i = 0; i < HOST_BYTES; i++)
               if (int'(wr_addr) == A_PAY0 + i) pay_q[i] <= wr_data;
         end
      end
   end

   assign en_o  = en_q;
   assign rpt_o = rpt_q;
   assign hdr_o = hdr_q;
   assign pay_o = pay_q;

   // R5
   oneshot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take && en_q[PK_AUD] && !rpt_q[PK_AUD] && !wr_ctla |=> !en_q[PK_AUD]);

   // R6
   repeat_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take && en_q[PK_AUD] && rpt_q[PK_AUD] && !wr_ctla |=> en_q[PK_AUD]);
endmodule

// File: rtl/aifb_sched.sv
module aifb_sched
   import aifb_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            frame_strobe,
   input  logic [NPKT-1:0] en,
   input  logic            done,
   output logic            take,
   output logic            busy,
   output pkt_e            cur
);
   logic [NPKT-1:0] pend_q;

   assign busy = |pend_q;
   assign take = frame_strobe && !busy;

   always_comb begin
      cur = PK_GEN;
      for (int k = NPKT-1; k >= 0; k--)
         if (pend_q[k]) cur = pkt_e'(k);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pend_q <= '0;
      else if (take) pend_q <= en;
      else if (done) pend_q[cur] <= 1'b0;
   end

   // R10
   no_new_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> ((pend_q & ~$past(pend_q)) == '0));

   // R7
   done_clears_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> ($countones(pend_q) == $countones($past(pend_q)) - 1));
endmodule

// File: rtl/aifb_stream.sv
module aifb_stream
   import aifb_pkg::*;
#(
   parameter int HOST_BYTES  = 5,
   parameter int PAYLOAD_LEN = 10
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           take,
   input  logic                           busy,
   input  pkt_e                           cur,
   input  logic [2:0][DW-1:0]             hdr,
   input  logic [HOST_BYTES-1:0][DW-1:0]  pay,
   input  logic                           out_ready,
   output logic                           out_valid,
   output logic [DW-1:0]                  out_data,
   output logic                           out_last,
   output logic                           done
);
   localparam int AUD_LEN = 4 + PAYLOAD_LEN;
   localparam int IW      = $clog2(AUD_LEN);

   logic [2:0][DW-1:0]             hdr_s;
   logic [HOST_BYTES-1:0][DW-1:0]  pay_s;
   logic [PAYLOAD_LEN-1:0][DW-1:0] body;
   logic [IW-1:0]                  idx, bidx;
   logic [DW-1:0]                  acc, chk;
   logic                           is_aud, end_beat;

   // host bytes fill the front of the payload, the tail is fixed zero
   for (genvar i = 0; i < PAYLOAD_LEN; i++) begin : g_body
      if (i < HOST_BYTES) begin : g_host
         assign body[i] = pay_s[i];
      end else begin : g_zero
         assign body[i] = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hdr_s <= '0;
         pay_s <= '0;
      end else if (take) begin
         hdr_s <= hdr;
         pay_s <= pay;
      end
   end

   always_comb begin
      acc = hdr_s[0] + hdr_s[1] + hdr_s[2];
      for (int i = 0; i < PAYLOAD_LEN; i++) acc = acc + body[i];
      chk = 8'h00 - acc;
   end

   assign is_aud   = (cur == PK_AUD);
   assign bidx     = idx - IW'(4);
   assign end_beat = is_aud ? (idx == IW'(AUD_LEN-1)) : 1'b1;

   always_comb begin
      out_data = '0;
      if (busy) begin
         case (cur)
            PK_GCP: out_data = TOK_GCP;
            PK_VID: out_data = TOK_VID;
            PK_GEN: out_data = TOK_GEN;
            default: begin
               if (idx < IW'(3))       out_data = hdr_s[idx[1:0]];
               else if (idx == IW'(3)) out_data = chk;
               else                    out_data = body[bidx];
            end
         endcase
      end
   end

   assign out_valid = busy;
   assign out_last  = busy && end_beat;
   assign done      = busy && out_ready && end_beat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      idx <= '0;
      else if (done)                   idx <= '0;
      else if (out_valid && out_ready) idx <= idx + IW'(1);
   end

   // R8
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
endmodule

// File: rtl/audio_ifr_pktbuf.sv
module audio_ifr_pktbuf
   import aifb_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int HOST_BYTES  = 5,
   parameter int PAYLOAD_LEN = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              frame_strobe,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [7:0]        out_data,
   output logic              out_last
);
   if (HOST_BYTES < 1 || HOST_BYTES > PAYLOAD_LEN) begin : g_bad_bytes
      $error("HOST_BYTES must lie in 1..PAYLOAD_LEN");
   end
   if (A_PAY0 + HOST_BYTES > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for the payload registers");
   end

   logic [NPKT-1:0]               en, rpt;
   logic [2:0][DW-1:0]            hdr;
   logic [HOST_BYTES-1:0][DW-1:0] pay;
   logic                          take, busy, done;
   pkt_e                          cur;

   aifb_regs #(.ADDR_W(ADDR_W), .HOST_BYTES(HOST_BYTES)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .take(take), .en_o(en), .rpt_o(rpt),
      .hdr_o(hdr), .pay_o(pay)
   );

   aifb_sched u_sched (
      .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe), .en(en),
      .done(done), .take(take), .busy(busy), .cur(cur)
   );

   aifb_stream #(.HOST_BYTES(HOST_BYTES), .PAYLOAD_LEN(PAYLOAD_LEN)) u_stream (
      .clk(clk), .rst_n(rst_n), .take(take), .busy(busy), .cur(cur),
      .hdr(hdr), .pay(pay), .out_ready(out_ready), .out_valid(out_valid),
      .out_data(out_data), .out_last(out_last), .done(done)
   );

   logic unused_rpt;
   assign unused_rpt = ^rpt;
endmodule

// File: tb/sim_audio_ifr_pktbuf.sv
module sim_audio_ifr_pktbuf;
   timeunit 1ns;
   timeprecision 1ps;
   import aifb_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n, wr_en, frame_strobe, out_ready;
   logic [3:0] wr_addr;
   logic [7:0] wr_data;
   logic       out_valid, out_last;
   logic [7:0] out_data;

   always #2 clk = ~clk;

   audio_ifr_pktbuf u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .frame_strobe(frame_strobe), .out_valid(out_valid),
      .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
   );

   int n_chk = 0;
   int n_fail = 0;
   logic [7:0] rx [16];
   int rx_n;

   // payload bytes 1..5, byte 1 in the top octet
   localparam logic [39:0] VEC [4] = '{
      40'h01_02_03_04_05,
      40'hFF_FF_FF_FF_FF,
      40'h80_00_7F_10_EF,
      40'h3C_A5_5A_C3_00
   };

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic strobe();
      @(negedge clk); frame_strobe = 1'b1;
      @(negedge clk); frame_strobe = 1'b0;
   endtask

   task automatic set_pay(input logic [39:0] p);
      for (int i = 0; i < 5; i++) wr(A_PAY0 + i, p[39-8*i -: 8]);
   endtask

   task automatic get_pkt();
      int g;
      g = 0; rx_n = 0;
      forever begin
         if (out_valid && out_ready) begin
            rx[rx_n] = out_data;
            rx_n++;
            if (out_last || rx_n == 16) break;
         end
         g++;
         if (g > 100) break;
         @(negedge clk);
      end
      @(negedge clk);
   endtask

   task automatic expect_audio(input string tag, input logic [7:0] t, input logic [7:0] v,
                               input logic [7:0] l, input logic [39:0] p);
      logic [7:0] e [14];
      logic [7:0] s;
      int bad;
      e[0] = t; e[1] = v; e[2] = l;
      for (int i = 0; i < 5; i++) e[4+i] = p[39-8*i -: 8];
      for (int i = 9; i < 14; i++) e[i] = 8'h00;
      s = t + v + l;
      for (int i = 4; i < 14; i++) s = s + e[i];
      e[3] = 8'h00 - s;
      get_pkt();
      check(rx_n == 14, {tag, " length"}, rx_n, 14);
      bad = -1;
      for (int i = 0; i < 14; i++) if (bad < 0 && i < rx_n && rx[i] !== e[i]) bad = i;
      if (bad < 0) check(1'b1, tag, 0, 0);
      else check(1'b0, {tag, " byte"}, int'(rx[bad]), int'(e[bad]));
   endtask

   task automatic expect_token(input string tag, input logic [7:0] tok);
      get_pkt();
      check(rx_n == 1 && rx[0] == tok, tag, (rx_n == 0) ? -1 : int'(rx[0]), int'(tok));
   endtask

   task automatic expect_quiet(input string tag);
      bit seen;
      seen = 1'b0;
      repeat (20) begin
         @(negedge clk);
         if (out_valid) seen = 1'b1;
      end
      check(!seen, tag, int'(seen), 0);
   endtask

   initial begin
      #600000;
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      frame_strobe = 1'b0; out_ready = 1'b1;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
      strobe();
      expect_quiet("R1 nothing enabled after reset");
      wr(A_CTLA, 8'h20);
      strobe();
      expect_audio("R1 default header and zero payload", 8'h84, 8'h01, 8'h0A, 40'h0);

      // R2 R3 table of payload vectors
      for (int v = 0; v < 4; v++) begin
         set_pay(VEC[v]);
         wr(A_CTLA, 8'h20);
         strobe();
         expect_audio("R2 R3 payload vector", 8'h84, 8'h01, 8'h0A, VEC[v]);
      end

      // R5 one-shot has disarmed
      strobe();
      expect_quiet("R5 one-shot not resent");

      // R6 repeat
      wr(A_CTLA, 8'h30);
      strobe(); expect_audio("R6 repeat frame 1", 8'h84, 8'h01, 8'h0A, VEC[3]);
      strobe(); expect_audio("R6 repeat frame 2", 8'h84, 8'h01, 8'h0A, VEC[3]);
      wr(A_CTLA, 8'h00);
      strobe(); expect_quiet("R6 stops after host clear");

      // R4 bit positions and descriptor codes
      wr(A_CTLB, 8'h02); strobe(); expect_token("R4 generic enable bit", 8'h81);
      wr(A_CTLB, 8'h08); strobe(); expect_token("R4 general control enable bit", 8'h03);
      wr(A_CTLA, 8'h02); strobe(); expect_token("R4 video enable bit", 8'h82);
      wr(A_CTLA, 8'h10); strobe(); expect_quiet("R4 repeat without enable");

      // R7 priority order
      wr(A_CTLA, 8'h22);
      wr(A_CTLB, 8'h0A);
      strobe();
      expect_token("R7 first general control", 8'h03);
      expect_token("R7 second video", 8'h82);
      expect_audio("R7 third audio", 8'h84, 8'h01, 8'h0A, VEC[3]);
      expect_token("R7 fourth generic", 8'h81);
      expect_quiet("R7 nothing after the four");

      // R8 backpressure
      out_ready = 1'b0;
      wr(A_CTLA, 8'h20);
      strobe();
      for (int i = 0; i < 4; i++) begin
         check(out_valid && out_data == 8'h84 && !out_last, "R8 hold under stall",
               int'(out_data), 8'h84);
         @(negedge clk);
      end
      out_ready = 1'b1;
      expect_audio("R8 packet intact after stall", 8'h84, 8'h01, 8'h0A, VEC[3]);

      // R9 payload write during transmission
      out_ready = 1'b0;
      wr(A_CTLA, 8'h20);
      strobe();
      set_pay(VEC[0]);
      out_ready = 1'b1;
      expect_audio("R9 in-flight packet keeps old payload", 8'h84, 8'h01, 8'h0A, VEC[3]);
      wr(A_CTLA, 8'h20);
      strobe();
      expect_audio("R9 new payload on next strobe", 8'h84, 8'h01, 8'h0A, VEC[0]);

      // R10 strobe while busy
      out_ready = 1'b0;
      wr(A_CTLA, 8'h20);
      strobe();
      wr(A_CTLB, 8'h08);
      strobe();
      out_ready = 1'b1;
      expect_audio("R10 only the first frame's packet", 8'h84, 8'h01, 8'h0A, VEC[0]);
      expect_quiet("R10 busy strobe ignored");
      strobe();
      expect_token("R10 armed packet waits for later strobe", 8'h03);

      // R11 host header
      wr(A_TYPE, 8'h55);
      wr(A_VER, 8'h02);
      wr(A_LEN, 8'h0B);
      wr(A_CTLA, 8'h20);
      strobe();
      expect_audio("R11 host header and checksum", 8'h55, 8'h02, 8'h0B, VEC[0]);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule